// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block arbitrates interrupt requests for a 16-bit processor core. Requests are grouped into sixteen priority slots. Each slot owns a word-aligned vector address at the top of the address space: the lowest slot sits at 0xFFE0, and every step up in priority adds two bytes, up to 0xFFFE for the highest slot. A maskable slot may be fed by up to eight source flags. Any one of those flags makes the slot pending, and the slot has its own enable bit.

Three classes of slot are treated differently. The top slot is the reset slot. It is raised by any of four reset causes, or when the core fetches an instruction from a forbidden address range. The slot below it is the non-maskable slot. It merges three sources, each with its own enable, and the global interrupt enable has no effect on it. All other slots are maskable and need both the global enable and their slot enable. Four slots have no sources and can never be chosen.

Each cycle the highest eligible slot is granted. The grant is a registered, one-cycle indication that carries the slot number and its vector address. The global enable and the non-maskable source enables are kept inside the block, and taking a grant updates them.

Top module: `ivc_top`

## Requirements
- R1: After a synchronous reset, `grant_valid`, `sys_reset`, `gie` and every bit of `nmi_en` read 0.
- R2: A grant for slot s presents `grant_slot` = s and `grant_vec` = 0xFFE0 + 2*s. Both appear one cycle after the cycle in which the request was eligible.
- R3: When several slots are eligible in the same cycle, the slot with the highest number is granted.
- R4: Maskable slot s (flag bits s*8 to s*8+7 of `flag_in`) is eligible only when at least one of its flags is set, `slot_en[s]` is 1, and `gie` is 1.
- R5: `gie_set` sets `gie` and `gie_clr` clears it. A maskable grant clears `gie` in the same edge that presents the grant, even when `gie_set` is asserted, so the grant lasts a single cycle.
- R6: Slot 14 (0xFFFC) is eligible when `nmi_src[k]` and `nmi_en[k]` are both 1 for some k, whatever the value of `gie`. `nmi_en_set` sets enable bits. A slot-14 grant clears all `nmi_en` bits and leaves `gie` unchanged.
- R7: Any bit of `rst_src` grants slot 15 (0xFFFE) on the next edge and raises `sys_reset` with it, ahead of every other slot. That grant clears `gie` and `nmi_en`.
- R8: When `fetch_valid` is 1 and `fetch_addr` lies in 0x0000..0x01FF or 0x0600..0x0BFF, slot 15 is granted and `sys_reset` rises on the next edge. Addresses outside those ranges, or any address with `fetch_valid` at 0, cause no reset.
- R9: Slots 2, 3, 7 and 11 are never granted, whatever their flags and enables. The general flag and enable bits of slots 14 and 15 have no effect either; those slots are driven only by their dedicated inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flag_in | input | 128 | Source flags, eight per slot; slot s uses bits s*8 to s*8+7 |
| slot_en | input | 16 | Per-slot enable for maskable slots |
| gie_set | input | 1 | Set global interrupt enable |
| gie_clr | input | 1 | Clear global interrupt enable |
| nmi_src | input | 3 | Non-maskable sources (pin, oscillator fault, flash access fault) |
| nmi_en_set | input | 3 | Set the matching non-maskable source enables |
| rst_src | input | 4 | Reset causes (power-up, pin, watchdog, key violation) |
| fetch_valid | input | 1 | An instruction fetch is being issued |
| fetch_addr | input | 16 | Fetch address |
| grant_valid | output | 1 | Grant indication |
| grant_slot | output | 4 | Granted slot number |
| grant_vec | output | 16 | Vector address of the granted slot |
| sys_reset | output | 1 | System reset request |
| gie | output | 1 | Global interrupt enable state |
| nmi_en | output | 3 | Non-maskable source enable state |

## Verification
Maskable requests are tried with the global enable off, with the slot enable off, and with both on. This shows that each gate blocks a grant alone. Sets of pending slots are built so that each winner differs from the runner-up only by its priority or by its enable. This tells a correct highest-first choice apart from a lowest-first one or from one that ignores enables. Flags on empty and special slots, non-maskable sources with and without their enables, and reset causes arriving together with non-maskable requests show the class boundaries. Fetch addresses on both sides of every forbidden-range edge tell exact bounds apart from off-by-one bounds.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_MASK  = 2'd1,
    CLS_NMI   = 2'd2,
    CLS_RESET = 2'd3
  } grant_class_e;

  function automatic logic in_range(input logic [31:0] addr,
                                    input logic [31:0] lo,
                                    input logic [31:0] hi);
    return (addr >= lo) && (addr <= hi);
  endfunction

endpackage

// File: rtl/ivc_fetch_guard.sv
module ivc_fetch_guard #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LO0    = 32'h0000,
  parameter int unsigned HI0    = 32'h01FF,
  parameter int unsigned LO1    = 32'h0600,
  parameter int unsigned HI1    = 32'h0BFF
) (
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              bad_fetch
);
  import ivc_pkg::*;

  logic [31:0] addr_ext;

  always_comb begin
    addr_ext  = 32'(fetch_addr);
    bad_fetch = fetch_valid &&
                (in_range(addr_ext, LO0, HI0) || in_range(addr_ext, LO1, HI1));
  end
endmodule

// File: rtl/ivc_slot_gate.sv
module ivc_slot_gate #(
  parameter int unsigned     NUM_SLOTS    = 16,
  parameter int unsigned     SRC_PER_SLOT = 8,
  parameter logic [NUM_SLOTS-1:0] EMPTY_MASK = 16'h088C,
  parameter int unsigned     RESET_SLOT   = 15,
  parameter int unsigned     NMI_SLOT     = 14
) (
  input  logic [NUM_SLOTS*SRC_PER_SLOT-1:0] flag_in,
  input  logic [NUM_SLOTS-1:0]              slot_en,
  input  logic                              gie,
  input  logic                              nmi_pend,
  input  logic                              rst_pend,
  output logic [NUM_SLOTS-1:0]              eligible
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [SRC_PER_SLOT-1:0] flags;
    assign flags = flag_in[s*SRC_PER_SLOT +: SRC_PER_SLOT];

    if (s == RESET_SLOT) begin : g_rst
      logic unused_flags;
      assign unused_flags = ^{flags, slot_en[s]};
      assign eligible[s]  = rst_pend;
    end else if (s == NMI_SLOT) begin : g_nmi
      logic unused_flags;
      assign unused_flags = ^{flags, slot_en[s]};
      assign eligible[s]  = nmi_pend;
    end else if (EMPTY_MASK[s]) begin : g_empty
      logic unused_flags;
      assign unused_flags = ^{flags, slot_en[s]};
      assign eligible[s]  = 1'b0;
    end else begin : g_mask
      assign eligible[s] = (|flags) && slot_en[s] && gie;
    end
  end
endmodule

// File: rtl/ivc_prio_pick.sv
module ivc_prio_pick #(
  parameter int unsigned NUM_SLOTS = 16,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0] eligible,
  output logic                 any,
  output logic [SLOT_W-1:0]    slot
);
  always_comb begin
    any  = 1'b0;
    slot = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (eligible[i]) begin
        any  = 1'b1;
        slot = SLOT_W'(i);
      end
    end
  end
endmodule

// File: rtl/ivc_top.sv
module ivc_top #(
  parameter int unsigned NUM_SLOTS    = 16,
  parameter int unsigned SRC_PER_SLOT = 8,
  parameter int unsigned NMI_SRCS     = 3,
  parameter int unsigned RST_SRCS     = 4,
  parameter int unsigned ADDR_W       = 16,
  parameter logic [15:0] VEC_BASE     = 16'hFFE0,
  parameter logic [NUM_SLOTS-1:0] EMPTY_MASK = 16'h088C,
  parameter int unsigned RESET_SLOT   = NUM_SLOTS - 1,
  parameter int unsigned NMI_SLOT     = NUM_SLOTS - 2,
  parameter int unsigned FORBID0_LO   = 32'h0000,
  parameter int unsigned FORBID0_HI   = 32'h01FF,
  parameter int unsigned FORBID1_LO   = 32'h0600,
  parameter int unsigned FORBID1_HI   = 32'h0BFF,
  localparam int unsigned SLOT_W      = $clog2(NUM_SLOTS),
  localparam int unsigned FLAG_W      = NUM_SLOTS * SRC_PER_SLOT
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [FLAG_W-1:0]     flag_in,
  input  logic [NUM_SLOTS-1:0]  slot_en,
  input  logic                  gie_set,
  input  logic                  gie_clr,
  input  logic [NMI_SRCS-1:0]   nmi_src,
  input  logic [NMI_SRCS-1:0]   nmi_en_set,
  input  logic [RST_SRCS-1:0]   rst_src,
  input  logic                  fetch_valid,
  input  logic [ADDR_W-1:0]     fetch_addr,
  output logic                  grant_valid,
  output logic [SLOT_W-1:0]     grant_slot,
  output logic [ADDR_W-1:0]     grant_vec,
  output logic                  sys_reset,
  output logic                  gie,
  output logic [NMI_SRCS-1:0]   nmi_en
);
  import ivc_pkg::*;

  logic                 bad_fetch;
  logic                 nmi_pend;
  logic                 rst_pend;
  logic [NUM_SLOTS-1:0] eligible;
  logic                 pick_any;
  logic [SLOT_W-1:0]    pick_slot;
  grant_class_e         pick_cls;
  logic [ADDR_W-1:0]    pick_vec;
  logic                 gie_d;
  logic [NMI_SRCS-1:0]  nmi_en_d;

  ivc_fetch_guard #(
    .ADDR_W(ADDR_W),
    .LO0(FORBID0_LO), .HI0(FORBID0_HI),
    .LO1(FORBID1_LO), .HI1(FORBID1_HI)
  ) u_guard (
    .fetch_valid(fetch_valid),
    .fetch_addr (fetch_addr),
    .bad_fetch  (bad_fetch)
  );

  assign nmi_pend = |(nmi_src & nmi_en);
  assign rst_pend = (|rst_src) || bad_fetch;

  ivc_slot_gate #(
    .NUM_SLOTS   (NUM_SLOTS),
    .SRC_PER_SLOT(SRC_PER_SLOT),
    .EMPTY_MASK  (EMPTY_MASK),
    .RESET_SLOT  (RESET_SLOT),
    .NMI_SLOT    (NMI_SLOT)
  ) u_gate (
    .flag_in (flag_in),
    .slot_en (slot_en),
    .gie     (gie),
    .nmi_pend(nmi_pend),
    .rst_pend(rst_pend),
    .eligible(eligible)
  );

  ivc_prio_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
    .eligible(eligible),
    .any     (pick_any),
    .slot    (pick_slot)
  );

  always_comb begin
    if (!pick_any)                             pick_cls = CLS_NONE;
    else if (pick_slot == SLOT_W'(RESET_SLOT)) pick_cls = CLS_RESET;
    else if (pick_slot == SLOT_W'(NMI_SLOT))   pick_cls = CLS_NMI;
    else                                       pick_cls = CLS_MASK;
  end

  assign pick_vec = ADDR_W'(VEC_BASE) + ADDR_W'({pick_slot, 1'b0});

  always_comb begin
    gie_d = gie;
    if (gie_set)      gie_d = 1'b1;
    else if (gie_clr) gie_d = 1'b0;
    if (pick_cls == CLS_MASK || pick_cls == CLS_RESET) gie_d = 1'b0;
  end

  always_comb begin
    nmi_en_d = nmi_en | nmi_en_set;
    if (pick_cls == CLS_NMI || pick_cls == CLS_RESET) nmi_en_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_valid <= 1'b0;
      grant_slot  <= '0;
      grant_vec   <= '0;
      sys_reset   <= 1'b0;
      gie         <= 1'b0;
      nmi_en      <= '0;
    end else begin
      grant_valid <= pick_any;
      grant_slot  <= pick_any ? pick_slot : '0;
      grant_vec   <= pick_any ? pick_vec : '0;
      sys_reset   <= (pick_cls == CLS_RESET);
      gie         <= gie_d;
      nmi_en      <= nmi_en_d;
    end
  end
endmodule

// File: rtl/ivc_checker.sv
module ivc_checker #(
  parameter int unsigned NUM_SLOTS  = 16,
  parameter int unsigned NMI_SRCS   = 3,
  parameter int unsigned ADDR_W     = 16,
  parameter logic [15:0] VEC_BASE   = 16'hFFE0,
  parameter logic [NUM_SLOTS-1:0] EMPTY_MASK = 16'h088C,
  parameter int unsigned RESET_SLOT = NUM_SLOTS - 1,
  parameter int unsigned NMI_SLOT   = NUM_SLOTS - 2,
  localparam int unsigned SLOT_W    = $clog2(NUM_SLOTS)
) (
  input logic                clk,
  input logic                rst,
  input logic                fetch_valid,
  input logic [ADDR_W-1:0]   fetch_addr,
  input logic                grant_valid,
  input logic [SLOT_W-1:0]   grant_slot,
  input logic [ADDR_W-1:0]   grant_vec,
  input logic                sys_reset,
  input logic                gie,
  input logic [NMI_SRCS-1:0] nmi_en
);
  logic is_mask_grant;
  logic fetch_bad;
  assign is_mask_grant = grant_valid && (grant_slot < SLOT_W'(NMI_SLOT));
  assign fetch_bad = fetch_valid &&
                     ((fetch_addr <= ADDR_W'(16'h01FF)) ||
                      ((fetch_addr >= ADDR_W'(16'h0600)) && (fetch_addr <= ADDR_W'(16'h0BFF))));

  p_vec_match_r2: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> (grant_vec == ADDR_W'(VEC_BASE) + ADDR_W'({grant_slot, 1'b0})));

  p_mask_needs_gie_r4: assert property (@(posedge clk) disable iff (rst)
    is_mask_grant |-> $past(gie));

  p_gie_drop_r5: assert property (@(posedge clk) disable iff (rst)
    is_mask_grant |-> !gie);

  p_nmi_en_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (grant_valid && grant_slot == SLOT_W'(NMI_SLOT)) |-> (nmi_en == '0));

  p_reset_vec_r7: assert property (@(posedge clk) disable iff (rst)
    sys_reset |-> (grant_valid && grant_slot == SLOT_W'(RESET_SLOT) && !gie));

  p_bad_fetch_r8: assert property (@(posedge clk) disable iff (rst)
    fetch_bad |=> sys_reset);

  p_empty_slot_r9: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> !EMPTY_MASK[grant_slot]);
endmodule

bind ivc_top ivc_checker #(
  .NUM_SLOTS (NUM_SLOTS),
  .NMI_SRCS  (NMI_SRCS),
  .ADDR_W    (ADDR_W),
  .VEC_BASE  (VEC_BASE),
  .EMPTY_MASK(EMPTY_MASK),
  .RESET_SLOT(RESET_SLOT),
  .NMI_SLOT  (NMI_SLOT)
) u_ivc_checker (
  .clk        (clk),
  .rst        (rst),
  .fetch_valid(fetch_valid),
  .fetch_addr (fetch_addr),
  .grant_valid(grant_valid),
  .grant_slot (grant_slot),
  .grant_vec  (grant_vec),
  .sys_reset  (sys_reset),
  .gie        (gie),
  .nmi_en     (nmi_en)
);

// File: tb/tb_ivc_top.sv
module tb_ivc_top;
  logic         clk = 1'b0;
  logic         rst;
  logic [127:0] flag_in;
  logic [15:0]  slot_en;
  logic         gie_set, gie_clr;
  logic [2:0]   nmi_src, nmi_en_set;
  logic [3:0]   rst_src;
  logic         fetch_valid;
  logic [15:0]  fetch_addr;
  logic         grant_valid;
  logic [3:0]   grant_slot;
  logic [15:0]  grant_vec;
  logic         sys_reset, gie;
  logic [2:0]   nmi_en;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  ivc_top dut (
    .clk(clk), .rst(rst), .flag_in(flag_in), .slot_en(slot_en),
    .gie_set(gie_set), .gie_clr(gie_clr), .nmi_src(nmi_src),
    .nmi_en_set(nmi_en_set), .rst_src(rst_src), .fetch_valid(fetch_valid),
    .fetch_addr(fetch_addr), .grant_valid(grant_valid), .grant_slot(grant_slot),
    .grant_vec(grant_vec), .sys_reset(sys_reset), .gie(gie), .nmi_en(nmi_en)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not finish actual=%0d expected<=100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_flag(input int slot, input int k);
    flag_in[slot*8 + k] = 1'b1;
  endtask

  task automatic idle;
    flag_in = '0; slot_en = '0; gie_set = 0; gie_clr = 0;
    nmi_src = '0; nmi_en_set = '0; rst_src = '0;
    fetch_valid = 0; fetch_addr = 16'h4000;
    rst = 1; tick; rst = 0;
  endtask

  task automatic raise_gie;
    gie_set = 1; tick; gie_set = 0;
  endtask

  task automatic t_reset_state;
    idle;
    chk("R1 grant_valid", 32'(grant_valid), 0);
    chk("R1 sys_reset", 32'(sys_reset), 0);
    chk("R1 gie", 32'(gie), 0);
    chk("R1 nmi_en", 32'(nmi_en), 0);
  endtask

  task automatic t_mask_gating;
    idle;
    set_flag(5, 3); slot_en[5] = 1;
    tick;
    chk("R4 no grant with gie off", 32'(grant_valid), 0);
    raise_gie;
    chk("R5 gie set", 32'(gie), 1);
    chk("R4 gie set same cycle no grant", 32'(grant_valid), 0);
    tick;
    chk("R4 grant valid", 32'(grant_valid), 1);
    chk("R2 slot 5", 32'(grant_slot), 5);
    chk("R2 vec slot 5", 32'(grant_vec), 32'hFFEA);
    chk("R5 gie cleared by grant", 32'(gie), 0);
    tick;
    chk("R5 single cycle grant", 32'(grant_valid), 0);
    idle;
    set_flag(6, 0); raise_gie;
    tick;
    chk("R4 slot enable off blocks", 32'(grant_valid), 0);
    chk("R4 gie untouched", 32'(gie), 1);
    gie_clr = 1; tick; gie_clr = 0;
    chk("R5 gie_clr", 32'(gie), 0);
  endtask

  task automatic t_priority;
    idle;
    set_flag(1, 7); set_flag(4, 0); set_flag(9, 2); set_flag(13, 5);
    slot_en = 16'h2212;
    raise_gie;
    tick;
    chk("R3 highest slot 13", 32'(grant_slot), 13);
    chk("R2 vec slot 13", 32'(grant_vec), 32'hFFFA);
    slot_en[13] = 0;
    raise_gie;
    gie_set = 1;
    tick;
    gie_set = 0;
    chk("R3 next slot 9", 32'(grant_slot), 9);
    chk("R2 vec slot 9", 32'(grant_vec), 32'hFFF2);
    chk("R5 grant beats gie_set", 32'(gie), 0);
  endtask

  task automatic t_empty_slots;
    idle;
    flag_in[11*8 +: 8] = 8'hFF; flag_in[7*8 +: 8] = 8'hFF;
    flag_in[3*8 +: 8]  = 8'hFF; flag_in[2*8 +: 8] = 8'hFF;
    flag_in[14*8 +: 8] = 8'hFF; flag_in[15*8 +: 8] = 8'hFF;
    slot_en = 16'hFFFF;
    raise_gie;
    tick;
    chk("R9 empty and special flags ignored", 32'(grant_valid), 0);
    chk("R9 no reset from flags", 32'(sys_reset), 0);
    chk("R9 gie kept", 32'(gie), 1);
    set_flag(0, 4);
    tick;
    chk("R9 lowest real slot wins", 32'(grant_slot), 0);
    chk("R2 vec slot 0", 32'(grant_vec), 32'hFFE0);
  endtask

  task automatic t_nmi;
    idle;
    gie_set = 1; nmi_en_set = 3'b010; tick;
    gie_set = 0; nmi_en_set = '0;
    chk("R6 nmi enable set", 32'(nmi_en), 32'b010);
    nmi_src = 3'b001;
    tick;
    chk("R6 disabled source ignored", 32'(grant_valid), 0);
    nmi_src = 3'b011; set_flag(13, 1); slot_en[13] = 1;
    tick;
    chk("R6 nmi slot granted", 32'(grant_slot), 14);
    chk("R6 nmi vector", 32'(grant_vec), 32'hFFFC);
    chk("R6 nmi enables cleared", 32'(nmi_en), 0);
    chk("R6 gie unchanged", 32'(gie), 1);
    tick;
    chk("R6 maskable after nmi", 32'(grant_slot), 13);
    idle;
    nmi_en_set = 3'b100; tick; nmi_en_set = '0;
    nmi_src = 3'b100;
    tick;
    chk("R6 nmi ignores gie off", 32'(grant_vec), 32'hFFFC);
  endtask

  task automatic t_reset_slot;
    idle;
    gie_set = 1; nmi_en_set = 3'b111; tick;
    gie_set = 0; nmi_en_set = '0;
    nmi_src = 3'b111; rst_src = 4'b0100;
    tick;
    chk("R7 sys_reset", 32'(sys_reset), 1);
    chk("R7 reset vector", 32'(grant_vec), 32'hFFFE);
    chk("R7 gie cleared", 32'(gie), 0);
    chk("R7 nmi_en cleared", 32'(nmi_en), 0);
    rst_src = '0; nmi_src = '0;
    tick;
    chk("R7 reset released", 32'(sys_reset), 0);
  endtask

  task automatic t_fetch;
    logic [15:0] addrs [8] = '{16'h0000, 16'h01FF, 16'h0200, 16'h05FF,
                               16'h0600, 16'h0BFF, 16'h0C00, 16'hFFFE};
    logic        expv  [8] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
    idle;
    for (int i = 0; i < 8; i++) begin
      fetch_valid = 1; fetch_addr = addrs[i];
      tick;
      chk($sformatf("R8 fetch %h", addrs[i]), 32'(sys_reset), 32'(expv[i]));
      fetch_valid = 0;
      tick;
    end
    fetch_valid = 0; fetch_addr = 16'h0100;
    tick;
    chk("R8 no fetch no reset", 32'(sys_reset), 0);
  endtask

  initial begin
    t_reset_state;
    t_mask_gating;
    t_priority;
    t_empty_slots;
    t_nmi;
    t_reset_slot;
    t_fetch;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule